// File: doc/BRIEF.md
# Serial Receiver with Processor Bus Access

This block turns an asynchronous serial line into bytes that a processor collects over a byte-wide bus. It runs from one receive clock at sixteen times the bit rate. The serial input passes through a two-flop synchronizer. A falling edge on the synchronized line starts a frame. Each bit is then sampled at a fixed count near the centre of its sixteen-clock cell, so an edge detected one clock late still lands well inside the cell.

A finished frame loads its data bits into a holding register and raises data-available. Three faults are tracked, each in its own status flag:
- a new word arriving while the previous one is still unread (overrun),
- a parity mismatch,
- a low stop bit (framing).

Overrun and parity are also combined onto one error pin.

The processor reaches the block through three chip selects, a read/write direction line and a write strobe. A read returns either the holding register or the status byte, picked by a register-select line. A write loads a small control field that turns parity on and picks even or odd parity.

Top module: `uart_rx_bus`

## Requirements
- R1: After reset the status byte reads 0x00, the holding register reads 0x00, and `err_flag` and `frame_err` are 0.
- R2: A frame starts on a high-to-low change of the synchronized line. If the line is back high at the start-bit sample point, the frame is abandoned and nothing is loaded.
- R3: Every bit is sampled once, 7 receive-clock counts after its cell begins (counted from start detection). Cells are 16 counts long. Data bits arrive least significant bit first.
- R4: At the stop-bit sample the data word is written to the holding register and data-available (status bit 0) is set.
- R5: Control bit 0 turns on a parity bit after the data bits. Control bit 1 picks even parity (data bits plus parity bit have an even number of ones) when 1 and odd parity when 0. A mismatch sets the parity flag, status bit 2.
- R6: A stop-bit sample of 0 sets the framing flag, status bit 3. The word is still loaded and data-available is still set.
- R7: Loading a word while data-available is already set sets the overrun flag, status bit 1. This does not happen when the holding register is read in that same cycle.
- R8: `err_flag` is high exactly when the overrun flag or the parity flag is set. The framing flag does not drive it.
- R9: A read is decoded when `sel_a`=1, `sel_b`=1, `sel_n`=0 and `dir_rd`=1. While decoded, `rd_data` shows the status byte if `reg_sel`=1 and the holding register if `reg_sel`=0. While not decoded, `rd_data` is 0.
- R10: A decoded holding-register read clears data-available, and a decoded status read clears the overrun, parity and framing flags. An event that sets a flag in the same cycle wins over the clear.
- R11: A write is decoded when `wr_stb`=1, `sel_a`=1, `sel_b`=1, `sel_n`=0 and `dir_rd`=0. It loads the control field from `wr_data[1:0]`. Any other combination leaves the control field unchanged.
- R12: The status byte layout is: bit 0 data-available, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 4 parity enable, bit 5 even parity. Bits 7:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, 16 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data line, idles high |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| dir_rd | input | 1 | Bus direction: 1 read, 0 write |
| wr_stb | input | 1 | Write strobe |
| reg_sel | input | 1 | Read target: 1 status, 0 holding register |
| wr_data | input | 8 | Write data; bits 1:0 form the control field |
| rd_data | output | 8 | Read data |
| data_avail | output | 1 | Data-available flag |
| err_flag | output | 1 | Overrun or parity error |
| frame_err | output | 1 | Framing error flag |

## Verification
Two functions can collide in one receive-clock cycle: the load of a new word and a processor read of the holding register. The bench sends two frames back to back and leaves the first word unread. It places a single-cycle holding read exactly on the stop-bit sample edge of the second frame. It then checks three things:
- the read returned the first word,
- the overrun flag stayed clear,
- data-available stayed set for the second word.

A plain back-to-back pair with no read serves as the contrast and must raise overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  localparam int ST_DA   = 0;
  localparam int ST_OE   = 1;
  localparam int ST_PE   = 2;
  localparam int ST_FE   = 3;
  localparam int ST_PEN  = 4;
  localparam int ST_EVEN = 5;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line,
  output logic fall
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign line = sh_q[STAGES-1];
  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS    = 8,
  parameter int OVERSAMPLE   = 16,
  parameter int SAMPLE_POINT = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line,
  input  logic                 fall,
  input  logic                 par_en,
  input  logic                 par_even,
  output logic                 load,
  output logic [DATA_BITS-1:0] word,
  output logic                 perr,
  output logic                 ferr
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_BITS + 3);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] CNT_SMP  = CNT_W'(SAMPLE_POINT);
  localparam logic [IDX_W-1:0] IDX_DLST = IDX_W'(DATA_BITS);
  localparam logic [IDX_W-1:0] IDX_PAR  = IDX_W'(DATA_BITS + 1);

  rx_state_e            st_q, st_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 pb_q, pb_d;
  logic                 exp_par;
  logic                 smp;

  assign exp_par = par_even ? (^sh_q) : ~(^sh_q);
  assign smp     = (st_q == RX_BUSY) && (cnt_q == CNT_SMP);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    pb_d  = pb_q;
    load  = 1'b0;
    perr  = 1'b0;
    ferr  = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (fall) begin
          st_d  = RX_BUSY;
          cnt_d = '0;
          idx_d = '0;
        end
      end
      default: begin
        cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        if (smp) begin
          if (idx_q == '0) begin
            if (line) st_d = RX_IDLE;
            idx_d = idx_q + 1'b1;
          end else if (idx_q <= IDX_DLST) begin
            sh_d  = {line, sh_q[DATA_BITS-1:1]};
            idx_d = idx_q + 1'b1;
          end else if ((idx_q == IDX_PAR) && par_en) begin
            pb_d  = line;
            idx_d = idx_q + 1'b1;
          end else begin
            load = 1'b1;
            ferr = ~line;
            perr = par_en && (pb_q != exp_par);
            st_d = RX_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      pb_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      pb_q  <= pb_d;
    end
  end

  assign word = sh_q;

  a_r2_fall_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_IDLE && fall) |=> (st_q == RX_BUSY));

  a_r4_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);

  a_r3_load_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (st_q == RX_IDLE));

endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int BUS_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] word,
  input  logic                 perr,
  input  logic                 ferr,
  input  logic                 rd_act,
  input  logic                 wr_act,
  input  logic                 reg_sel,
  input  logic [BUS_W-1:0]     wr_data,
  output logic [BUS_W-1:0]     rd_data,
  output logic                 da,
  output logic                 oe,
  output logic                 pe,
  output logic                 fe,
  output logic                 par_en,
  output logic                 par_even
);

  logic [DATA_BITS-1:0] hold_q, hold_d;
  logic                 da_d, oe_d, pe_d, fe_d;
  logic [1:0]           ctrl_q, ctrl_d;
  logic                 clr_da, clr_st;
  logic [BUS_W-1:0]     status;
  logic [BUS_W-1:0]     hold_bus;

  assign clr_da = rd_act & ~reg_sel;
  assign clr_st = rd_act &  reg_sel;

  always_comb begin
    hold_d = load ? word : hold_q;
    da_d   = load ? 1'b1 : (clr_da ? 1'b0 : da);
    oe_d   = (load && da && !clr_da) ? 1'b1 : (clr_st ? 1'b0 : oe);
    pe_d   = (load && perr) ? 1'b1 : (clr_st ? 1'b0 : pe);
    fe_d   = (load && ferr) ? 1'b1 : (clr_st ? 1'b0 : fe);
    ctrl_d = wr_act ? wr_data[1:0] : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      da     <= 1'b0;
      oe     <= 1'b0;
      pe     <= 1'b0;
      fe     <= 1'b0;
      ctrl_q <= '0;
    end else begin
      hold_q <= hold_d;
      da     <= da_d;
      oe     <= oe_d;
      pe     <= pe_d;
      fe     <= fe_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign par_en   = ctrl_q[0];
  assign par_even = ctrl_q[1];

  always_comb begin
    status          = '0;
    status[ST_DA]   = da;
    status[ST_OE]   = oe;
    status[ST_PE]   = pe;
    status[ST_FE]   = fe;
    status[ST_PEN]  = ctrl_q[0];
    status[ST_EVEN] = ctrl_q[1];
    hold_bus        = BUS_W'(hold_q);
    if (!rd_act)      rd_data = '0;
    else if (reg_sel) rd_data = status;
    else              rd_data = hold_bus;
  end

  a_r4_load_sets_da: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> da);

  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (load && da && !clr_da) |=> oe);

  a_r7_no_overrun_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (load && clr_da && !oe && !clr_st) |=> !oe);

  a_r10_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_da && !load) |=> !da);

  a_r10_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_st && !load) |=> (!oe && !pe && !fe));

  a_r11_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_act |=> $stable(ctrl_q));

endmodule

// File: rtl/uart_rx_bus.sv
module uart_rx_bus #(
  parameter int DATA_BITS    = 8,
  parameter int OVERSAMPLE   = 16,
  parameter int SAMPLE_POINT = 7,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_in,
  input  logic       sel_a,
  input  logic       sel_b,
  input  logic       sel_n,
  input  logic       dir_rd,
  input  logic       wr_stb,
  input  logic       reg_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       data_avail,
  output logic       err_flag,
  output logic       frame_err
);

  localparam int BUS_W = 8;

  logic                 line, fall;
  logic                 load, perr, ferr;
  logic [DATA_BITS-1:0] word;
  logic                 rd_act, wr_act;
  logic                 da, oe, pe, fe;
  logic                 par_en, par_even;

  assign rd_act = sel_a & sel_b & ~sel_n &  dir_rd;
  assign wr_act = sel_a & sel_b & ~sel_n & ~dir_rd & wr_stb;

  uart_rx_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ser_in),
    .line (line),
    .fall (fall)
  );

  uart_rx_frame #(
    .DATA_BITS   (DATA_BITS),
    .OVERSAMPLE  (OVERSAMPLE),
    .SAMPLE_POINT(SAMPLE_POINT)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .line    (line),
    .fall    (fall),
    .par_en  (par_en),
    .par_even(par_even),
    .load    (load),
    .word    (word),
    .perr    (perr),
    .ferr    (ferr)
  );

  uart_rx_regs #(
    .DATA_BITS(DATA_BITS),
    .BUS_W    (BUS_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .word    (word),
    .perr    (perr),
    .ferr    (ferr),
    .rd_act  (rd_act),
    .wr_act  (wr_act),
    .reg_sel (reg_sel),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .da      (da),
    .oe      (oe),
    .pe      (pe),
    .fe      (fe),
    .par_en  (par_en),
    .par_even(par_even)
  );

  assign data_avail = da;
  assign err_flag   = oe | pe;
  assign frame_err  = fe;

  a_r8_pin_follows_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (load && perr) |=> err_flag);

endmodule

// File: tb/tb_uart_rx_bus.sv
module tb_uart_rx_bus;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_in;
  logic       sel_a, sel_b, sel_n, dir_rd, wr_stb, reg_sel;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       data_avail, err_flag, frame_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  uart_rx_bus dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .sel_n     (sel_n),
    .dir_rd    (dir_rd),
    .wr_stb    (wr_stb),
    .reg_sel   (reg_sel),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .data_avail(data_avail),
    .err_flag  (err_flag),
    .frame_err (frame_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] st(input bit da, input bit oe, input bit pe,
                                    input bit fe, input bit pen, input bit ev);
    return {2'b00, ev, pen, fe, pe, oe, da};
  endfunction

  task automatic bus_idle();
    sel_a = 1'b0; sel_b = 1'b0; sel_n = 1'b1; dir_rd = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic bus_rd(input bit rs, output logic [7:0] v);
    @(negedge clk);
    sel_a = 1'b1; sel_b = 1'b1; sel_n = 1'b0; dir_rd = 1'b1; reg_sel = rs;
    #1 v = rd_data;
    @(posedge clk);
    @(negedge clk);
    bus_idle();
  endtask

  task automatic bus_wr(input logic [7:0] d, input bit good);
    @(negedge clk);
    sel_a = 1'b1; sel_b = 1'b1; sel_n = good ? 1'b0 : 1'b1;
    dir_rd = 1'b0; wr_stb = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    bus_idle();
  endtask

  task automatic send_frame(input logic [7:0] b, input bit use_par, input bit pbit,
                            input bit stopv, input bit hit, output logic [7:0] hit_val);
    logic [10:0] seq;
    int n;
    n   = use_par ? 11 : 10;
    seq = use_par ? {stopv, pbit, b, 1'b0} : {1'b0, stopv, b, 1'b0};
    hit_val = 8'h00;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ser_in = seq[k];
      if (hit && k == n - 1) begin
        repeat (10) @(posedge clk);
        @(negedge clk);
        sel_a = 1'b1; sel_b = 1'b1; sel_n = 1'b0; dir_rd = 1'b1; reg_sel = 1'b0;
        #1 hit_val = rd_data;
        @(posedge clk);
        @(negedge clk);
        bus_idle();
        repeat (5) @(posedge clk);
      end else begin
        repeat (16) @(posedge clk);
      end
    end
    @(negedge clk);
    ser_in = 1'b1;
    repeat (20) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, h;
    rst_n = 1'b0; ser_in = 1'b1; reg_sel = 1'b0; wr_data = 8'h00;
    bus_idle();
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    bus_rd(1'b1, v); chk(v == 8'h00, "R1 status", v, 8'h00);
    bus_rd(1'b0, v); chk(v == 8'h00, "R1 holding", v, 8'h00);
    chk({err_flag, frame_err} == 2'b00, "R1 pins", {6'd0, err_flag, frame_err}, 8'h00);

    // R9 undecoded read drives 0
    chk(rd_data == 8'h00, "R9 idle bus", rd_data, 8'h00);

    // R3 R4 R12 sweep all bytes without parity
    for (int b = 0; b < 256; b++) begin
      send_frame(8'(b), 1'b0, 1'b0, 1'b1, 1'b0, h);
      bus_rd(1'b1, v); chk(v == st(1,0,0,0,0,0), "R4 R12 status", v, st(1,0,0,0,0,0));
      bus_rd(1'b0, v); chk(v == 8'(b), "R3 data", v, 8'(b));
      bus_rd(1'b1, v); chk(v == 8'h00, "R10 da cleared", v, 8'h00);
    end

    // R11 write rejected when a select is wrong
    bus_wr(8'h03, 1'b0);
    bus_rd(1'b1, v); chk(v == 8'h00, "R11 ignored write", v, 8'h00);

    // R5 even parity sweep
    bus_wr(8'h03, 1'b1);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] b;
      b = 8'(i * 4 + 1);
      send_frame(b, 1'b1, ^b, 1'b1, 1'b0, h);
      bus_rd(1'b1, v); chk(v == st(1,0,0,0,1,1), "R5 even ok", v, st(1,0,0,0,1,1));
      bus_rd(1'b0, v); chk(v == b, "R5 even data", v, b);
      bus_rd(1'b1, v);
    end
    // R5 R8 parity error
    send_frame(8'h5A, 1'b1, 1'b1, 1'b1, 1'b0, h);
    bus_rd(1'b0, v); chk(v == 8'h5A, "R5 data on perr", v, 8'h5A);
    chk(err_flag == 1'b1, "R8 perr pin", {7'd0, err_flag}, 8'h01);
    bus_rd(1'b1, v); chk(v == st(0,0,1,0,1,1), "R5 perr status", v, st(0,0,1,0,1,1));
    chk(err_flag == 1'b0, "R10 perr cleared pin", {7'd0, err_flag}, 8'h00);

    // R5 odd parity sweep
    bus_wr(8'h01, 1'b1);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] b;
      b = 8'(i * 4 + 2);
      send_frame(b, 1'b1, ~^b, 1'b1, 1'b0, h);
      bus_rd(1'b1, v); chk(v == st(1,0,0,0,1,0), "R5 odd ok", v, st(1,0,0,0,1,0));
      bus_rd(1'b0, v); chk(v == b, "R5 odd data", v, b);
      bus_rd(1'b1, v);
    end

    // R6 R8 framing error
    bus_wr(8'h00, 1'b1);
    send_frame(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, h);
    chk(frame_err == 1'b1, "R6 fe pin", {7'd0, frame_err}, 8'h01);
    chk(err_flag == 1'b0, "R8 fe not on err", {7'd0, err_flag}, 8'h00);
    bus_rd(1'b1, v); chk(v == st(1,0,0,1,0,0), "R6 fe status", v, st(1,0,0,1,0,0));
    bus_rd(1'b0, v); chk(v == 8'hC3, "R6 word kept", v, 8'hC3);

    // R2 false start
    @(negedge clk) ser_in = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) ser_in = 1'b1;
    repeat (200) @(posedge clk);
    chk(data_avail == 1'b0, "R2 false start", {7'd0, data_avail}, 8'h00);

    // R7 R8 overrun
    send_frame(8'h11, 1'b0, 1'b0, 1'b1, 1'b0, h);
    send_frame(8'h22, 1'b0, 1'b0, 1'b1, 1'b0, h);
    chk(err_flag == 1'b1, "R8 oe pin", {7'd0, err_flag}, 8'h01);
    // R9 undecoded read does not clear
    @(negedge clk);
    sel_a = 1'b1; sel_b = 1'b0; sel_n = 1'b0; dir_rd = 1'b1; reg_sel = 1'b0;
    #1 chk(rd_data == 8'h00, "R9 no decode", rd_data, 8'h00);
    @(posedge clk); @(negedge clk); bus_idle();
    chk(data_avail == 1'b1, "R9 no clear", {7'd0, data_avail}, 8'h01);
    bus_rd(1'b1, v); chk(v == st(1,1,0,0,0,0), "R7 overrun", v, st(1,1,0,0,0,0));
    bus_rd(1'b0, v); chk(v == 8'h22, "R7 newest word", v, 8'h22);

    // R7 R10 load coinciding with holding read
    send_frame(8'h33, 1'b0, 1'b0, 1'b1, 1'b0, h);
    send_frame(8'h44, 1'b0, 1'b0, 1'b1, 1'b1, h);
    chk(h == 8'h33, "R10 coincident read value", h, 8'h33);
    bus_rd(1'b1, v); chk(v == st(1,0,0,0,0,0), "R7 coincident no overrun", v, st(1,0,0,0,0,0));
    bus_rd(1'b0, v); chk(v == 8'h44, "R4 coincident word", v, 8'h44);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule